// File: doc/BRIEF.md
# Bidirectional Ring Data Relay Node

This block is one node of a closed ring that shares reference pixels and rate-control values among parallel encoder units. Every node has two ring ports, an upper one and a lower one, each carrying one data word per valid cycle and a last marker on the final word of a transfer. The upper port of a node is wired to the lower port of the next node in the ring. One node is strapped as master with `is_master`. The other nodes relay words around the ring and present a copy of each relayed word on a local receive output.

A round has two phases. In the upward phase the master takes words from its local source and sends them out of its upper port. Each non-master node passes every word arriving on its lower port straight on to its upper port. The master counts the words it sent and the words that come back on its lower port. Once the source has delivered its last word and the two counts match, the phase is complete. The downward phase then runs in the same way in the opposite direction: the master sends on its lower port and words return on its upper port. A round ends when both phases are done. Completion rests only on the counts, so the number of pipeline stages between nodes has no effect on correctness.

Master states: `M_IDLE` waits for `start` and moves to `M_SEND_UP`. `M_SEND_UP` accepts source words and moves to `M_DRAIN_UP` when the last word is accepted. `M_DRAIN_UP` moves to `M_SEND_DN` when the counts balance. `M_SEND_DN` moves to `M_DRAIN_DN` on the last word. `M_DRAIN_DN` returns to `M_IDLE` when the counts balance.

Relay states: `F_IDLE` waits for a word on either port. A lower-port word that is not last moves it to `F_UP`; an upper-port word that is not last moves it to `F_DN`. `F_UP` and `F_DN` return to `F_IDLE` on a word carrying the last marker.

Top module: `ring_relay_node`

## Requirements
- R1: After reset, every valid output (`up_out_valid`, `lo_out_valid`, `rx_valid`), the pulse outputs (`phase_done`, `round_done`, `proto_err`) and `src_ready` are 0.
- R2: In the master, `start` in idle raises `src_ready` from the next cycle. Each source word accepted in the upward phase appears on `up_out_*` in the next cycle with the same data and last marker. `lo_out_valid` stays 0 throughout the upward phase.
- R3: A relay node in `F_IDLE` or `F_UP` that receives a word on `lo_in_*` drives it on `up_out_*` in the next cycle. In that same cycle it shows the word on `rx_data` with `rx_valid`=1 and `rx_dir`=0 (0 means travelling upward).
- R4: A relay node in `F_IDLE` or `F_DN` that receives a word on `up_in_*` drives it on `lo_out_*` in the next cycle. In that same cycle it shows the word on `rx_*` with `rx_dir`=1.
- R5: The master pulses `phase_done` for one cycle only after the source's last word of the phase has been accepted and the number of words received on the return port equals the number sent. It never pulses before that point, and the received count never exceeds the sent count.
- R6: After the upward `phase_done`, the master enters the downward phase without a new `start`. Source words then leave on `lo_out_*` one cycle after acceptance, and returned words are counted on `up_in_*`.
- R7: `round_done` pulses only in the same cycle as the downward `phase_done`. The master then returns to idle, with `src_ready` at 0 until the next `start`.
- R8: A round completes with every word delivered in order to every relay node for any added link latency between nodes.
- R9: A relay node in `F_UP` that receives a word on `up_in_*` pulses `proto_err` in the next cycle and does not forward that word. The symmetric case holds in `F_DN`.
- R10: The sent and received counters restart at zero for each phase, so each phase may carry a different number of words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| is_master | input | 1 | Static strap: 1 makes this node the ring master |
| start | input | 1 | Master only: begin a round when idle |
| src_valid | input | 1 | Local source word valid (master) |
| src_data | input | DATA_W | Local source word |
| src_last | input | 1 | Last source word of the current phase |
| src_ready | output | 1 | Master accepts source words |
| up_in_valid | input | 1 | Upper port receive valid |
| up_in_data | input | DATA_W | Upper port receive data |
| up_in_last | input | 1 | Upper port receive last marker |
| up_out_valid | output | 1 | Upper port send valid |
| up_out_data | output | DATA_W | Upper port send data |
| up_out_last | output | 1 | Upper port send last marker |
| lo_in_valid | input | 1 | Lower port receive valid |
| lo_in_data | input | DATA_W | Lower port receive data |
| lo_in_last | input | 1 | Lower port receive last marker |
| lo_out_valid | output | 1 | Lower port send valid |
| lo_out_data | output | DATA_W | Lower port send data |
| lo_out_last | output | 1 | Lower port send last marker |
| rx_valid | output | 1 | Relay node: locally captured word valid |
| rx_data | output | DATA_W | Locally captured word |
| rx_dir | output | 1 | Direction of captured word: 0 upward, 1 downward |
| phase_done | output | 1 | Master: one-cycle pulse when a direction completes |
| round_done | output | 1 | Master: one-cycle pulse when both directions complete |
| proto_err | output | 1 | Relay node: one-cycle pulse on a word against the active direction |

## Verification
On every cycle, the assertions check the one-cycle relay of a word from the lower port to the upper port. They also check that the port opposite to the active direction stays silent, that the returned count never exceeds the sent count, that `round_done` never pulses without `phase_done`, and that source readiness drops after the last word. The bench scenarios alone show the rest. They show that complete rounds deliver every word in order to every node of a three-node ring, with zero and with several cycles of added link latency, and with different word counts in the two phases. They also show that `phase_done` arrives only after all words have returned, and that a word sent against the active direction raises the error and is dropped.

// File: rtl/ring_relay_pkg.sv
package ring_relay_pkg;

    typedef enum logic [2:0] {
        M_IDLE,
        M_SEND_UP,
        M_DRAIN_UP,
        M_SEND_DN,
        M_DRAIN_DN
    } master_state_e;

    typedef enum logic [1:0] {
        F_IDLE,
        F_UP,
        F_DN
    } fwd_state_e;

    localparam logic DIR_UPWARD   = 1'b0;
    localparam logic DIR_DOWNWARD = 1'b1;

endpackage

// File: rtl/ring_relay_counter.sv
module ring_relay_counter #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      count <= '0;
        else if (clr)    count <= '0;
        else if (inc)    count <= count + 1'b1;
    end
endmodule

// File: rtl/ring_relay_master.sv
module ring_relay_master
    import ring_relay_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              start,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    input  logic              src_last,
    output logic              src_ready,
    input  logic              lo_in_valid,
    input  logic              up_in_valid,
    output logic              up_out_valid,
    output logic [DATA_W-1:0] up_out_data,
    output logic              up_out_last,
    output logic              lo_out_valid,
    output logic [DATA_W-1:0] lo_out_data,
    output logic              lo_out_last,
    output logic              phase_done,
    output logic              round_done
);
    master_state_e state, nxt;
    logic [CNT_W-1:0] sent_cnt, back_cnt;
    logic accept, back_valid, balanced, cnt_clr, in_up, in_dn;

    assign in_up      = (state == M_SEND_UP) || (state == M_DRAIN_UP);
    assign in_dn      = (state == M_SEND_DN) || (state == M_DRAIN_DN);
    assign src_ready  = (state == M_SEND_UP) || (state == M_SEND_DN);
    assign accept     = src_valid && src_ready;
    assign back_valid = (in_up && lo_in_valid) || (in_dn && up_in_valid);
    assign balanced   = (sent_cnt == back_cnt);

    ring_relay_counter #(.W(CNT_W)) u_sent (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(accept), .count(sent_cnt));
    ring_relay_counter #(.W(CNT_W)) u_back (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(back_valid), .count(back_cnt));

    always_comb begin
        nxt = state;
        unique case (state)
            M_IDLE:     if (enable && start)       nxt = M_SEND_UP;
            M_SEND_UP:  if (accept && src_last)    nxt = M_DRAIN_UP;
            M_DRAIN_UP: if (balanced)              nxt = M_SEND_DN;
            M_SEND_DN:  if (accept && src_last)    nxt = M_DRAIN_DN;
            M_DRAIN_DN: if (balanced)              nxt = M_IDLE;
            default:                               nxt = M_IDLE;
        endcase
    end

    assign cnt_clr    = ((state == M_IDLE) && (nxt == M_SEND_UP)) ||
                        ((state == M_DRAIN_UP) && balanced);
    assign phase_done = ((state == M_DRAIN_UP) || (state == M_DRAIN_DN)) && balanced;
    assign round_done = (state == M_DRAIN_DN) && balanced;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= M_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_out_valid <= 1'b0;
            up_out_data  <= '0;
            up_out_last  <= 1'b0;
            lo_out_valid <= 1'b0;
            lo_out_data  <= '0;
            lo_out_last  <= 1'b0;
        end else begin
            up_out_valid <= accept && (state == M_SEND_UP);
            up_out_data  <= src_data;
            up_out_last  <= src_last;
            lo_out_valid <= accept && (state == M_SEND_DN);
            lo_out_data  <= src_data;
            lo_out_last  <= src_last;
        end
    end

    // R2: the lower port stays quiet during the upward phase
    p_up_phase_lower_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_up |=> !lo_out_valid);
    // R5: words never return faster than they were sent
    p_back_not_above_sent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        back_cnt <= sent_cnt);
    // R6: readiness drops once the last source word is taken
    p_last_ends_send_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid && src_ready && src_last) |=> !src_ready);
    // R7: round completion only together with a phase completion
    p_round_with_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
        round_done |-> phase_done);
endmodule

// File: rtl/ring_relay_fwd.sv
module ring_relay_fwd
    import ring_relay_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              up_in_valid,
    input  logic [DATA_W-1:0] up_in_data,
    input  logic              up_in_last,
    input  logic              lo_in_valid,
    input  logic [DATA_W-1:0] lo_in_data,
    input  logic              lo_in_last,
    output logic              up_out_valid,
    output logic [DATA_W-1:0] up_out_data,
    output logic              up_out_last,
    output logic              lo_out_valid,
    output logic [DATA_W-1:0] lo_out_data,
    output logic              lo_out_last,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_dir,
    output logic              proto_err
);
    fwd_state_e state, nxt;
    logic take_lo, take_up, clash, lo_v, up_v;

    assign lo_v = enable && lo_in_valid;
    assign up_v = enable && up_in_valid;

    always_comb begin
        nxt     = state;
        take_lo = 1'b0;
        take_up = 1'b0;
        clash   = 1'b0;
        unique case (state)
            F_IDLE: begin
                if (lo_v) begin
                    take_lo = 1'b1;
                    clash   = up_v;
                    if (!lo_in_last) nxt = F_UP;
                end else if (up_v) begin
                    take_up = 1'b1;
                    if (!up_in_last) nxt = F_DN;
                end
            end
            F_UP: begin
                take_lo = lo_v;
                clash   = up_v;
                if (lo_v && lo_in_last) nxt = F_IDLE;
            end
            F_DN: begin
                take_up = up_v;
                clash   = lo_v;
                if (up_v && up_in_last) nxt = F_IDLE;
            end
            default: nxt = F_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= F_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_out_valid <= 1'b0;
            up_out_data  <= '0;
            up_out_last  <= 1'b0;
            lo_out_valid <= 1'b0;
            lo_out_data  <= '0;
            lo_out_last  <= 1'b0;
            rx_valid     <= 1'b0;
            rx_data      <= '0;
            rx_dir       <= DIR_UPWARD;
            proto_err    <= 1'b0;
        end else begin
            up_out_valid <= take_lo;
            up_out_data  <= lo_in_data;
            up_out_last  <= lo_in_last;
            lo_out_valid <= take_up;
            lo_out_data  <= up_in_data;
            lo_out_last  <= up_in_last;
            rx_valid     <= take_lo || take_up;
            rx_data      <= take_lo ? lo_in_data : up_in_data;
            rx_dir       <= take_lo ? DIR_UPWARD : DIR_DOWNWARD;
            proto_err    <= clash;
        end
    end

    // R3: a lower-port word in the upward or idle state leaves on the upper port next cycle
    p_lower_to_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_v && state != F_DN) |=> (up_out_valid && up_out_data == $past(lo_in_data)));
    // R9: nothing goes downward while the upward direction is active
    p_up_state_blocks_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == F_UP) |=> !lo_out_valid);
    // R9: nothing goes upward while the downward direction is active
    p_dn_state_blocks_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == F_DN) |=> !up_out_valid);
endmodule

// File: rtl/ring_relay_node.sv
module ring_relay_node #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_master,
    input  logic              start,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    input  logic              src_last,
    output logic              src_ready,
    input  logic              up_in_valid,
    input  logic [DATA_W-1:0] up_in_data,
    input  logic              up_in_last,
    output logic              up_out_valid,
    output logic [DATA_W-1:0] up_out_data,
    output logic              up_out_last,
    input  logic              lo_in_valid,
    input  logic [DATA_W-1:0] lo_in_data,
    input  logic              lo_in_last,
    output logic              lo_out_valid,
    output logic [DATA_W-1:0] lo_out_data,
    output logic              lo_out_last,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_dir,
    output logic              phase_done,
    output logic              round_done,
    output logic              proto_err
);
    logic              m_up_v, m_up_l, m_lo_v, m_lo_l;
    logic [DATA_W-1:0] m_up_d, m_lo_d;
    logic              f_up_v, f_up_l, f_lo_v, f_lo_l;
    logic [DATA_W-1:0] f_up_d, f_lo_d;
    logic              f_rx_v, f_rx_dir, f_err;
    logic [DATA_W-1:0] f_rx_d;

    ring_relay_master #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_master (
        .clk(clk), .rst_n(rst_n), .enable(is_master), .start(start),
        .src_valid(src_valid), .src_data(src_data), .src_last(src_last),
        .src_ready(src_ready),
        .lo_in_valid(lo_in_valid), .up_in_valid(up_in_valid),
        .up_out_valid(m_up_v), .up_out_data(m_up_d), .up_out_last(m_up_l),
        .lo_out_valid(m_lo_v), .lo_out_data(m_lo_d), .lo_out_last(m_lo_l),
        .phase_done(phase_done), .round_done(round_done));

    ring_relay_fwd #(.DATA_W(DATA_W)) u_fwd (
        .clk(clk), .rst_n(rst_n), .enable(!is_master),
        .up_in_valid(up_in_valid), .up_in_data(up_in_data), .up_in_last(up_in_last),
        .lo_in_valid(lo_in_valid), .lo_in_data(lo_in_data), .lo_in_last(lo_in_last),
        .up_out_valid(f_up_v), .up_out_data(f_up_d), .up_out_last(f_up_l),
        .lo_out_valid(f_lo_v), .lo_out_data(f_lo_d), .lo_out_last(f_lo_l),
        .rx_valid(f_rx_v), .rx_data(f_rx_d), .rx_dir(f_rx_dir), .proto_err(f_err));

    assign up_out_valid = is_master ? m_up_v : f_up_v;
    assign up_out_data  = is_master ? m_up_d : f_up_d;
    assign up_out_last  = is_master ? m_up_l : f_up_l;
    assign lo_out_valid = is_master ? m_lo_v : f_lo_v;
    assign lo_out_data  = is_master ? m_lo_d : f_lo_d;
    assign lo_out_last  = is_master ? m_lo_l : f_lo_l;
    assign rx_valid     = f_rx_v && !is_master;
    assign rx_data      = f_rx_d;
    assign rx_dir       = f_rx_dir;
    assign proto_err    = f_err && !is_master;
endmodule

// File: tb/tb_ring_relay_node.sv
module tb_ring_relay_node;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int link_dly = 0;

    // master (dut) bench-driven inputs
    logic          start = 0, src_valid = 0, src_last = 0;
    logic [DW-1:0] src_data = '0;

    // ring wires
    logic m_src_ready, m_pd, m_rd, m_err, m_rxv, m_rxdir;
    logic [DW-1:0] m_rxd;
    logic m_uov, m_uol, m_lov, m_lol, m_uiv, m_uil, m_liv, m_lil;
    logic [DW-1:0] m_uod, m_lod, m_uid, m_lid;
    logic a_sr, a_pd, a_rd, a_err, a_rxv, a_rxdir;
    logic [DW-1:0] a_rxd;
    logic a_uov, a_uol, a_lov, a_lol, a_liv, a_lil;
    logic [DW-1:0] a_uod, a_lod, a_lid;
    logic b_sr, b_pd, b_rd, b_err, b_rxv, b_rxdir;
    logic [DW-1:0] b_rxd;
    logic b_uov, b_uol, b_lov, b_lol;
    logic [DW-1:0] b_uod, b_lod;

    // variable-latency link between dut and node a (both directions)
    logic [DW+1:0] fw_pipe [0:7];
    logic [DW+1:0] bw_pipe [0:7];
    always_ff @(posedge clk) begin
        fw_pipe[0] <= {m_uov, m_uol, m_uod};
        bw_pipe[0] <= {a_lov, a_lol, a_lod};
        for (int i = 1; i < 8; i++) begin
            fw_pipe[i] <= fw_pipe[i-1];
            bw_pipe[i] <= bw_pipe[i-1];
        end
    end
    always_comb begin
        if (link_dly == 0) begin
            {a_liv, a_lil, a_lid} = {m_uov, m_uol, m_uod};
            {m_uiv, m_uil, m_uid} = {a_lov, a_lol, a_lod};
        end else begin
            {a_liv, a_lil, a_lid} = fw_pipe[link_dly-1];
            {m_uiv, m_uil, m_uid} = bw_pipe[link_dly-1];
        end
        {m_liv, m_lil, m_lid} = {b_uov, b_uol, b_uod};
    end

    ring_relay_node #(.DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .is_master(1'b1), .start(start),
        .src_valid(src_valid), .src_data(src_data), .src_last(src_last), .src_ready(m_src_ready),
        .up_in_valid(m_uiv), .up_in_data(m_uid), .up_in_last(m_uil),
        .up_out_valid(m_uov), .up_out_data(m_uod), .up_out_last(m_uol),
        .lo_in_valid(m_liv), .lo_in_data(m_lid), .lo_in_last(m_lil),
        .lo_out_valid(m_lov), .lo_out_data(m_lod), .lo_out_last(m_lol),
        .rx_valid(m_rxv), .rx_data(m_rxd), .rx_dir(m_rxdir),
        .phase_done(m_pd), .round_done(m_rd), .proto_err(m_err));

    ring_relay_node #(.DATA_W(DW)) node_a (
        .clk(clk), .rst_n(rst_n), .is_master(1'b0), .start(1'b0),
        .src_valid(1'b0), .src_data('0), .src_last(1'b0), .src_ready(a_sr),
        .up_in_valid(b_lov), .up_in_data(b_lod), .up_in_last(b_lol),
        .up_out_valid(a_uov), .up_out_data(a_uod), .up_out_last(a_uol),
        .lo_in_valid(a_liv), .lo_in_data(a_lid), .lo_in_last(a_lil),
        .lo_out_valid(a_lov), .lo_out_data(a_lod), .lo_out_last(a_lol),
        .rx_valid(a_rxv), .rx_data(a_rxd), .rx_dir(a_rxdir),
        .phase_done(a_pd), .round_done(a_rd), .proto_err(a_err));

    ring_relay_node #(.DATA_W(DW)) node_b (
        .clk(clk), .rst_n(rst_n), .is_master(1'b0), .start(1'b0),
        .src_valid(1'b0), .src_data('0), .src_last(1'b0), .src_ready(b_sr),
        .up_in_valid(m_lov), .up_in_data(m_lod), .up_in_last(m_lol),
        .up_out_valid(b_uov), .up_out_data(b_uod), .up_out_last(b_uol),
        .lo_in_valid(a_uov), .lo_in_data(a_uod), .lo_in_last(a_uol),
        .lo_out_valid(b_lov), .lo_out_data(b_lod), .lo_out_last(b_lol),
        .rx_valid(b_rxv), .rx_data(b_rxd), .rx_dir(b_rxdir),
        .phase_done(b_pd), .round_done(b_rd), .proto_err(b_err));

    // standalone relay node driven directly by the bench
    logic          s_uiv = 0, s_uil = 0, s_liv = 0, s_lil = 0;
    logic [DW-1:0] s_uid = '0, s_lid = '0;
    logic s_sr, s_pd, s_rd, s_err, s_rxv, s_rxdir, s_uov, s_uol, s_lov, s_lol;
    logic [DW-1:0] s_rxd, s_uod, s_lod;

    ring_relay_node #(.DATA_W(DW)) node_s (
        .clk(clk), .rst_n(rst_n), .is_master(1'b0), .start(1'b0),
        .src_valid(1'b0), .src_data('0), .src_last(1'b0), .src_ready(s_sr),
        .up_in_valid(s_uiv), .up_in_data(s_uid), .up_in_last(s_uil),
        .up_out_valid(s_uov), .up_out_data(s_uod), .up_out_last(s_uol),
        .lo_in_valid(s_liv), .lo_in_data(s_lid), .lo_in_last(s_lil),
        .lo_out_valid(s_lov), .lo_out_data(s_lod), .lo_out_last(s_lol),
        .rx_valid(s_rxv), .rx_data(s_rxd), .rx_dir(s_rxdir),
        .phase_done(s_pd), .round_done(s_rd), .proto_err(s_err));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitors for captured words and returned words
    logic          cur_dir = 0;
    logic [DW-1:0] exp_base = '0;
    int a_cnt = 0, b_cnt = 0, ret_cnt = 0;
    always @(negedge clk) if (rst_n) begin
        if (a_rxv) begin
            chk(a_rxd == exp_base + DW'(a_cnt) && a_rxdir == cur_dir, "R8 node_a order", int'(a_rxd), int'(exp_base) + a_cnt);
            a_cnt++;
        end
        if (b_rxv) begin
            chk(b_rxd == exp_base + DW'(b_cnt) && b_rxdir == cur_dir, "R8 node_b order", int'(b_rxd), int'(exp_base) + b_cnt);
            b_cnt++;
        end
        if (!cur_dir && m_liv) ret_cnt++;
        if (cur_dir && m_uiv) ret_cnt++;
        chk(!(a_err || b_err), "R9 ring no error", int'(a_err || b_err), 0);
    end

    task automatic feed(input logic [DW-1:0] base, input int n, input logic dir);
        for (int i = 0; i < n; i++) begin
            src_valid = 1; src_data = base + DW'(i); src_last = (i == n - 1);
            @(negedge clk);
            if (!dir) begin
                chk(m_uov && m_uod == base + DW'(i) && m_uol == (i == n - 1), "R2 upper send", int'(m_uod), int'(base) + i);
                chk(!m_lov, "R2 lower quiet", int'(m_lov), 0);
            end else begin
                chk(m_lov && m_lod == base + DW'(i) && m_lol == (i == n - 1), "R6 lower send", int'(m_lod), int'(base) + i);
            end
        end
        src_valid = 0; src_last = 0;
    endtask

    task automatic wait_done(input int n, input string req, input bit want_round);
        int t = 0;
        while (!m_pd && t < 400) begin
            @(negedge clk); t++;
        end
        chk(m_pd, req, int'(m_pd), 1);
        chk(ret_cnt == n, "R5 all returned before done", ret_cnt, n);
        chk(a_cnt == n && b_cnt == n, "R8 every node captured", a_cnt + b_cnt, 2 * n);
        chk(m_rd == want_round, "R7 round_done with phase", int'(m_rd), int'(want_round));
    endtask

    task automatic run_round(input logic [DW-1:0] base, input int n_up, input int n_dn, input int dly);
        link_dly = dly;
        cur_dir = 0; exp_base = base; a_cnt = 0; b_cnt = 0; ret_cnt = 0;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        chk(m_src_ready, "R2 ready after start", int'(m_src_ready), 1);
        feed(base, n_up, 0);
        chk(!m_pd, "R5 no early done", int'(m_pd), 0);
        wait_done(n_up, "R5 upward phase_done", 0);
        cur_dir = 1; exp_base = base + 16'h0100; a_cnt = 0; b_cnt = 0; ret_cnt = 0;
        @(negedge clk);
        chk(m_src_ready, "R6 down phase without start", int'(m_src_ready), 1);
        feed(base + 16'h0100, n_dn, 1);
        wait_done(n_dn, "R10 downward phase_done", 1);
        @(negedge clk);
        chk(!m_src_ready && !m_pd, "R7 idle after round", int'(m_src_ready), 0);
        repeat (3) @(negedge clk);
        chk(!m_src_ready, "R7 stays idle without start", int'(m_src_ready), 0);
    endtask

    task automatic error_case();
        @(negedge clk);
        s_liv = 1; s_lid = 16'h0055; s_lil = 0;
        @(negedge clk);
        chk(s_uov && s_uod == 16'h0055, "R3 relay up", int'(s_uod), 16'h55);
        chk(s_rxv && s_rxd == 16'h0055 && s_rxdir == 0, "R3 capture dir 0", int'(s_rxdir), 0);
        s_liv = 0; s_uiv = 1; s_uid = 16'h00AA; s_uil = 1;
        @(negedge clk);
        chk(s_err, "R9 proto_err raised", int'(s_err), 1);
        chk(!s_lov, "R9 word dropped", int'(s_lov), 0);
        s_uiv = 0; s_liv = 1; s_lid = 16'h0056; s_lil = 1;
        @(negedge clk);
        chk(s_uov && s_uod == 16'h0056 && s_uol && !s_err, "R3 last word closes", int'(s_uod), 16'h56);
        s_liv = 0; s_lil = 0; s_uiv = 1; s_uid = 16'h0077; s_uil = 1;
        @(negedge clk);
        chk(s_lov && s_lod == 16'h0077 && s_lol, "R4 relay down", int'(s_lod), 16'h77);
        chk(s_rxv && s_rxdir == 1 && !s_err, "R4 capture dir 1", int'(s_rxdir), 1);
        s_uiv = 0; s_uil = 0;
        @(negedge clk);
        chk(!s_lov && !s_uov && !s_rxv, "R4 no stray output", int'(s_lov), 0);
    endtask

    task automatic reset_case();
        chk(!m_uov && !m_lov && !m_src_ready && !m_pd && !m_rd, "R1 master reset", int'(m_src_ready), 0);
        chk(!a_uov && !a_lov && !a_rxv && !a_err && !s_err, "R1 relay reset", int'(a_rxv), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        reset_case();
        rst_n = 1;
        @(negedge clk);
        run_round(16'h1000, 4, 7, 0);
        run_round(16'h2000, 9, 2, 5);
        run_round(16'h3000, 1, 1, 3);
        error_case();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule